// File: doc/BRIEF.md
# Serial Line Configuration and Bit-Rate Generator

This block turns three configuration words into the settings a serial transmitter and receiver need. A 6-bit line-control word selects the data width, the number of stop bits and the parity mode. From these the block works out the total frame length. A nonzero integer divisor and a 3-bit fractional value set the bit period. The block then produces a single-cycle 16x oversample tick and a once-per-bit tick from the reference clock.

Each configuration word has its own write strobe. On any write, the written words are combined with the held copies of the others, and the active settings are rebuilt at that same clock edge. There is one exception. If the divisor that results is zero, the active settings and the running tick phase are left untouched, and the written words are only held. An applied update restarts the generator at the start of a bit. The serializer, deserializer and bus interface sit outside this block.

Top module: `uart_line_baud`

## Requirements
- R1: `data_bits` equals line-control bits [1:0] plus 5, covering 5 to 8.
- R2: `stop_bits` is 2 when line-control bit 2 is set and 1 when it is clear.
- R3: `parity_mode` is 0 (none) when line-control bit 5 is clear. When bit 5 is set, it is 2 (even) if bit 3 is set and 1 (odd) if bit 3 is clear. Bit 3 has no effect when bit 5 is clear.
- R4: `frame_len` equals 1 + data bits + stop bits, plus 1 when parity is enabled.
- R5: With active divisor D and fraction F, consecutive `bit_tick` pulses are exactly 16*D + 16 + F clock cycles apart.
- R6: Each bit holds 16 oversample slots. The first F slots last D+2 cycles and the rest last D+1. `os_tick` is high in the last cycle of each slot, and `bit_tick` is high together with the 16th `os_tick` of each bit.
- R7: `os_tick` never stays high for two consecutive cycles.
- R8: When a write leaves the divisor register at zero, the active frame settings, the tick period and the tick phase are all unchanged. Words written while the divisor register is zero are held, and they take effect at the next write that leaves a nonzero divisor.
- R9: An applied update takes effect at its write edge and restarts the generator. The first `os_tick` follows after the first slot length minus one cycles, and the first `bit_tick` comes in the cycle 16*D + 15 + F edges after the write edge. A tick that was due in the write cycle itself is still issued with the old settings.
- R10: After reset, all configuration words are zero. The outputs show 5 data bits, 1 stop bit, no parity and a frame length of 7, and no tick is produced.
- R11: Words written in the same cycle, with a nonzero divisor among the results, take effect together at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lc_we | input | 1 | Line-control write strobe |
| lc_wdata | input | 6 | Line-control word |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Integer divisor |
| frac_we | input | 1 | Fraction write strobe |
| frac_wdata | input | 3 | Fractional cycle count per bit |
| data_bits | output | 4 | Active data bits per frame |
| stop_bits | output | 2 | Active stop bits per frame |
| parity_mode | output | 2 | 0 none, 1 odd, 2 even |
| frame_len | output | 4 | Total bits per frame |
| os_tick | output | 1 | 16x oversample pulse |
| bit_tick | output | 1 | One-bit-period pulse |

## Verification
The two functions that can fall in the same cycle are an applied configuration write and a bit tick that is due under the old settings. The bench lines a write up with the exact cycle in which the old period ends. It confirms that the old tick is still seen in that cycle and that the new period then starts counting from the write edge. The same collision is also provoked with a write of a zero divisor, which must leave both the pending tick and the phase after it untouched.

// File: rtl/uart_lcb_pkg.sv
package uart_lcb_pkg;

    localparam int LC_W      = 6;
    localparam int FRAC_W    = 3;
    localparam int OS_RATE   = 16;
    localparam int SLOT_W    = $clog2(OS_RATE);

    localparam int LC_WIDTH_LSB = 0;
    localparam int LC_STOP2     = 2;
    localparam int LC_EVEN      = 3;
    localparam int LC_PAR_ON    = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2
    } parity_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic [1:0] stop_bits;
        parity_e    parity;
        logic [3:0] frame_len;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_line(input logic [LC_W-1:0] lc);
        frame_cfg_t r;
        r.data_bits = 4'd5 + {2'b00, lc[LC_WIDTH_LSB +: 2]};
        r.stop_bits = lc[LC_STOP2] ? 2'd2 : 2'd1;
        if (!lc[LC_PAR_ON])
            r.parity = PAR_NONE;
        else if (lc[LC_EVEN])
            r.parity = PAR_EVEN;
        else
            r.parity = PAR_ODD;
        r.frame_len = 4'd1 + r.data_bits + {2'b00, r.stop_bits}
                    + ((r.parity != PAR_NONE) ? 4'd1 : 4'd0);
        return r;
    endfunction

endpackage

// File: rtl/ulb_cfg_regs.sv
module ulb_cfg_regs
    import uart_lcb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lc_we,
    input  logic [LC_W-1:0]   lc_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              frac_we,
    input  logic [FRAC_W-1:0] frac_wdata,
    output logic [LC_W-1:0]   act_lc,
    output logic [DIV_W-1:0]  act_div,
    output logic [FRAC_W-1:0] act_frac,
    output logic              apply
);

    logic [LC_W-1:0]   lc_q,   lc_n;
    logic [DIV_W-1:0]  div_q,  div_n;
    logic [FRAC_W-1:0] frac_q, frac_n;
    logic              any_we;

    always_comb begin
        lc_n   = lc_we   ? lc_wdata   : lc_q;
        div_n  = div_we  ? div_wdata  : div_q;
        frac_n = frac_we ? frac_wdata : frac_q;
        any_we = lc_we | div_we | frac_we;
        apply  = any_we && (div_n != '0);
    end

    // held copies of the written words
    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q   <= '0;
            div_q  <= '0;
            frac_q <= '0;
        end else begin
            lc_q   <= lc_n;
            div_q  <= div_n;
            frac_q <= frac_n;
        end
    end

    // active settings, only replaced when the divisor is nonzero
    always_ff @(posedge clk) begin
        if (rst) begin
            act_lc   <= '0;
            act_div  <= '0;
            act_frac <= '0;
        end else if (apply) begin
            act_lc   <= lc_n;
            act_div  <= div_n;
            act_frac <= frac_n;
        end
    end

    assert_zero_div_R8: assert property (@(posedge clk) disable iff (rst)
        (div_we && div_wdata == '0) |=>
            ($stable(act_lc) && $stable(act_div) && $stable(act_frac)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!lc_we && !div_we && !frac_we) |=>
            ($stable(act_lc) && $stable(act_div) && $stable(act_frac)));

    assert_apply_div_R9: assert property (@(posedge clk) disable iff (rst)
        (div_we && div_wdata != '0) |=> (act_div == $past(div_wdata)));

    assert_apply_lc_R11: assert property (@(posedge clk) disable iff (rst)
        (lc_we && div_we && div_wdata != '0) |=> (act_lc == $past(lc_wdata)));

endmodule

// File: rtl/ulb_frame_decode.sv
module ulb_frame_decode
    import uart_lcb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [LC_W-1:0] act_lc,
    output frame_cfg_t      cfg
);

    always_comb cfg = decode_line(act_lc);

    assert_width_range_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg.data_bits >= 4'd5 && cfg.data_bits <= 4'd8));

    assert_stop_range_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.stop_bits == 2'd1 || cfg.stop_bits == 2'd2));

    assert_parity_code_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg.parity != 2'd3));

    assert_frame_range_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg.frame_len >= 4'd7 && cfg.frame_len <= 4'd12));

endmodule

// File: rtl/ulb_baud_gen.sv
module ulb_baud_gen
    import uart_lcb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [DIV_W-1:0]  act_div,
    input  logic [FRAC_W-1:0] act_frac,
    output logic              os_tick,
    output logic              bit_tick
);

    localparam int CNT_W = DIV_W + 1;
    localparam int PER_W = DIV_W + SLOT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  slot_len;
    logic [CNT_W-1:0]  slot_last;
    logic              stretch;
    logic              running;

    always_comb begin
        running   = (act_div != '0);
        stretch   = (slot_q < SLOT_W'(act_frac));
        slot_len  = {1'b0, act_div} + CNT_W'(1) + (stretch ? CNT_W'(1) : CNT_W'(0));
        slot_last = slot_len - CNT_W'(1);
        os_tick   = running && (cnt_q == slot_last);
        bit_tick  = os_tick && (slot_q == SLOT_W'(OS_RATE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !running) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (cnt_q == slot_last) begin
            cnt_q  <= '0;
            slot_q <= (slot_q == SLOT_W'(OS_RATE - 1)) ? '0 : slot_q + SLOT_W'(1);
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // observation counters for the period and slot-count checks
    logic [PER_W-1:0]  per_q;
    logic [PER_W-1:0]  per_exp;
    logic [SLOT_W-1:0] os_seen_q;

    always_comb
        per_exp = {1'b0, act_div, {SLOT_W{1'b0}}} + PER_W'(OS_RATE - 1) + PER_W'(act_frac);

    always_ff @(posedge clk) begin
        if (rst || restart || bit_tick) begin
            per_q     <= '0;
            os_seen_q <= '0;
        end else begin
            if (running) per_q <= per_q + PER_W'(1);
            if (os_tick) os_seen_q <= os_seen_q + SLOT_W'(1);
        end
    end

    assert_bit_period_R5: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (per_q == per_exp));

    assert_slot_count_R6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (os_seen_q == SLOT_W'(OS_RATE - 1)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        os_tick |=> !os_tick);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (act_div == '0 && $stable(act_div)) |-> (per_q == '0));

endmodule

// File: rtl/uart_line_baud.sv
module uart_line_baud
    import uart_lcb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lc_we,
    input  logic [5:0]        lc_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              frac_we,
    input  logic [2:0]        frac_wdata,
    output logic [3:0]        data_bits,
    output logic [1:0]        stop_bits,
    output logic [1:0]        parity_mode,
    output logic [3:0]        frame_len,
    output logic              os_tick,
    output logic              bit_tick
);

    logic [LC_W-1:0]   act_lc;
    logic [DIV_W-1:0]  act_div;
    logic [FRAC_W-1:0] act_frac;
    logic              apply;
    frame_cfg_t        cfg;

    ulb_cfg_regs #(.DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .lc_we      (lc_we),
        .lc_wdata   (lc_wdata),
        .div_we     (div_we),
        .div_wdata  (div_wdata),
        .frac_we    (frac_we),
        .frac_wdata (frac_wdata),
        .act_lc     (act_lc),
        .act_div    (act_div),
        .act_frac   (act_frac),
        .apply      (apply)
    );

    ulb_frame_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .act_lc (act_lc),
        .cfg    (cfg)
    );

    ulb_baud_gen #(.DIV_W(DIV_W)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .restart  (apply),
        .act_div  (act_div),
        .act_frac (act_frac),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    always_comb begin
        data_bits   = cfg.data_bits;
        stop_bits   = cfg.stop_bits;
        parity_mode = cfg.parity;
        frame_len   = cfg.frame_len;
    end

endmodule

// File: tb/uart_line_baud_test.sv
module uart_line_baud_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        lc_we, div_we, frac_we;
    logic [5:0]  lc_wdata;
    logic [15:0] div_wdata;
    logic [2:0]  frac_wdata;
    logic [3:0]  data_bits;
    logic [1:0]  stop_bits;
    logic [1:0]  parity_mode;
    logic [3:0]  frame_len;
    logic        os_tick, bit_tick;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_line_baud #(.DIV_W(16)) uut (
        .clk(clk), .rst(rst),
        .lc_we(lc_we), .lc_wdata(lc_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .frac_we(frac_we), .frac_wdata(frac_wdata),
        .data_bits(data_bits), .stop_bits(stop_bits),
        .parity_mode(parity_mode), .frame_len(frame_len),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    // {line word, data bits, stop bits, parity code, frame length}
    localparam logic [19:0] VEC [9] = '{
        {8'h00, 4'd5, 2'd1, 2'd0, 4'd7},
        {8'h03, 4'd8, 2'd1, 2'd0, 4'd10},
        {8'h07, 4'd8, 2'd2, 2'd0, 4'd11},
        {8'h2B, 4'd8, 2'd1, 2'd2, 4'd11},
        {8'h21, 4'd6, 2'd1, 2'd1, 4'd9},
        {8'h26, 4'd7, 2'd2, 2'd1, 4'd11},
        {8'h08, 4'd5, 2'd1, 2'd0, 4'd7},
        {8'h2C, 4'd5, 2'd2, 2'd2, 4'd9},
        {8'h3F, 4'd8, 2'd2, 2'd2, 4'd12}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_frame(input string req, input int db, input int sb,
                               input int pm, input int fl);
        check({req, " data"},   int'(data_bits),   db);
        check({req, " stop"},   int'(stop_bits),   sb);
        check({req, " parity"}, int'(parity_mode), pm);
        check({req, " length"}, int'(frame_len),   fl);
    endtask

    // drive at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic lw, input logic [5:0] l, input logic dw,
                      input logic [15:0] d, input logic fw, input logic [2:0] f);
        lc_we = lw;  lc_wdata = l;
        div_we = dw; div_wdata = d;
        frac_we = fw; frac_wdata = f;
        @(negedge clk);
        lc_we = 1'b0; div_we = 1'b0; frac_we = 1'b0;
    endtask

    // walks one full bit from cycle 0 and compares every tick cycle
    task automatic run_bit(input int d, input int f, input string tag);
        int per = 16 * d + 16 + f;
        int nxt = d + ((f > 0) ? 1 : 0);
        int slot = 0;
        int bad_os = 0;
        int bad_bit = 0;
        int pulse2 = 0;
        logic prev_os = 1'b0;
        for (int c = 0; c < per; c++) begin
            logic eo = (c == nxt);
            logic eb = eo && (slot == 15);
            if (os_tick !== eo) bad_os++;
            if (bit_tick !== eb) bad_bit++;
            if (prev_os && os_tick) pulse2++;
            prev_os = os_tick;
            if (eo) begin
                slot++;
                nxt = nxt + d + 1 + ((slot < f) ? 1 : 0);
            end
            @(negedge clk);
        end
        check({"R6 slot pattern ", tag}, bad_os, 0);
        check({"R5 bit period ", tag}, bad_bit, 0);
        check({"R7 single pulse ", tag}, pulse2, 0);
    endtask

    task automatic count_idle(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (os_tick || bit_tick) seen++;
            @(negedge clk);
        end
        check(tag, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        lc_we = 1'b0; div_we = 1'b0; frac_we = 1'b0;
        lc_wdata = '0; div_wdata = '0; frac_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state and silence
        check_frame("R10 reset", 5, 1, 0, 7);
        count_idle(60, "R10 no ticks after reset");

        // R10/R8: writes while divisor is zero stay inactive
        wr(1'b1, 6'h3F, 1'b0, 16'd0, 1'b1, 3'd4);
        check_frame("R8 held while div zero", 5, 1, 0, 7);
        count_idle(40, "R8 no ticks while div zero");

        // R1 R2 R3 R4 R11: decode table, all three words written together
        foreach (VEC[i]) begin
            wr(1'b1, VEC[i][17:12], 1'b1, 16'd1, 1'b1, 3'd0);
            check_frame($sformatf("R1-vector %0d R11", i),
                        int'(VEC[i][11:8]), int'(VEC[i][7:6]),
                        int'(VEC[i][5:4]), int'(VEC[i][3:0]));
        end

        // R5 R6 R9: several periods from a fresh write
        wr(1'b0, 6'h00, 1'b1, 16'd2, 1'b1, 3'd0);
        run_bit(2, 0, "d2 f0 first R9");
        run_bit(2, 0, "d2 f0 second");
        wr(1'b0, 6'h00, 1'b1, 16'd3, 1'b1, 3'd5);
        run_bit(3, 5, "d3 f5 first R9");
        run_bit(3, 5, "d3 f5 second");
        wr(1'b0, 6'h00, 1'b0, 16'd0, 1'b1, 3'd7);
        run_bit(3, 7, "fraction-only write");
        wr(1'b0, 6'h00, 1'b1, 16'd1, 1'b1, 3'd7);
        run_bit(1, 7, "d1 f7");

        // R9: write lands in the cycle of a due bit tick
        wr(1'b0, 6'h00, 1'b1, 16'd2, 1'b1, 3'd0);
        repeat (47) @(negedge clk);
        check("R9 old tick in write cycle", int'(bit_tick), 1);
        wr(1'b0, 6'h00, 1'b1, 16'd4, 1'b1, 3'd1);
        run_bit(4, 1, "after collision R9");

        // R8: zero divisor write keeps settings and phase
        wr(1'b1, 6'h07, 1'b1, 16'd4, 1'b1, 3'd2);
        repeat (10) @(negedge clk);
        wr(1'b1, 6'h03, 1'b1, 16'd0, 1'b0, 3'd0);
        check_frame("R8 zero div keeps frame", 8, 2, 0, 11);
        wr(1'b1, 6'h2B, 1'b0, 16'd0, 1'b0, 3'd0);
        check_frame("R8 line write ignored", 8, 2, 0, 11);
        repeat (68) @(negedge clk);
        check("R8 phase kept, no early tick", int'(bit_tick), 0);
        @(negedge clk);
        check("R8 phase kept, tick on time", int'(bit_tick), 1);
        wr(1'b0, 6'h00, 1'b1, 16'd5, 1'b0, 3'd0);
        check_frame("R8 held line word applied", 8, 1, 2, 11);
        run_bit(5, 2, "held fraction applied R8");

        // R10: reset in mid-run
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_frame("R10 reset mid-run", 5, 1, 0, 7);
        count_idle(120, "R10 silent after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule